// File: doc/BRIEF.md
# Byte-Wise Host Reader for a 12-Bit Sampling Converter

This block sits on the host side of a parallel 12-bit successive-approximation converter whose result is read over an 8-bit path. A request pulse or a periodic tick starts one transaction. The block drives a chip-select strobe, a read strobe and a byte-select level. With all of them low the converter starts a conversion. The block then waits, through a two-flop synchronizer, for the converter's busy line to go low and return high. After a settle delay it performs a low-byte read with the byte-select low and then a high-byte read with the byte-select high. It joins the two reads into one 12-bit sample.

The sample is held on a valid/ready output until it is accepted. All analog timing limits are parameters counted in system-clock cycles: the read pulse width, the spacing between read operations, the data settle time after busy returns, and the minimum spacing between conversion starts. If the converter does not finish in time, the busy wait ends with a one-cycle error pulse and the transaction is dropped.

Top module: `adc_byte_reader`

## Requirements
- R1: After reset, `sel_n` and `rd_n` are high, `hi_byte` is low, and `smp_valid` and `err_timeout` are low.
- R2: A conversion is started by driving `sel_n` and `rd_n` low together while `hi_byte` is low. This strobe is the first read operation of each transaction.
- R3: After the start strobe, no further read strobe is issued until the synchronized `busy_n` has been seen low and then high again. A read issued while the converter is busy is a fault.
- R4: The low-byte read is performed with `hi_byte` low, at least `SETTLE_CYC` cycles after busy returns high. Sample bits 7..0 are taken from `bus_d[7:0]` in the last cycle of that strobe.
- R5: The high-byte read is performed with `hi_byte` high, and `hi_byte` does not change while `rd_n` is low. Sample bits 11..8 are taken from `bus_d[3:0]` in the last cycle of that strobe, and `bus_d[7:4]` is ignored. Every pair of consecutive read strobes is separated by at least `SPACE_CYC` cycles with `rd_n` high.
- R6: Every read strobe holds `rd_n` (with `sel_n`) low for exactly `PULSE_CYC` cycles.
- R7: `smp_valid` stays high with `smp_data` stable until a cycle with `smp_ready` high. It falls after that cycle. While `smp_valid` is high, no strobe is issued.
- R8: Consecutive conversion-start strobes begin at least `CONV_GAP_CYC` cycles apart.
- R9: If busy has not been seen low and then high within `TIMEOUT_CYC` cycles after the start strobe, `err_timeout` pulses high for one cycle. No data read follows and no sample is presented, and later requests are served normally.
- R10: `conv_req` and `conv_tick` have the same effect. One request that arrives while a transaction or an unaccepted sample is outstanding is kept and served afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_req | input | 1 | Sample request pulse |
| conv_tick | input | 1 | Periodic sample tick |
| sel_n | output | 1 | Converter chip-select strobe, active low |
| rd_n | output | 1 | Converter read strobe, active low |
| hi_byte | output | 1 | Byte select: high selects the upper bits and blocks conversion starts |
| busy_n | input | 1 | Converter busy, low while converting (asynchronous) |
| bus_d | input | 8 | Converter data lines |
| smp_data | output | 12 | Assembled sample |
| smp_valid | output | 1 | Sample valid |
| smp_ready | input | 1 | Sample accepted by the consumer |
| err_timeout | output | 1 | One-cycle pulse when the busy wait expires |

## Verification
The bench builds the block with a 2-cycle pulse, 3-cycle spacing, 2-cycle settle, a 24-cycle conversion spacing and a 20-cycle timeout. These short values make every 13th code of the 12-bit range, the full-scale code, backpressure on the output, a queued second request and a converter that never goes busy all fit within a short run. A behavioural converter model watches every strobe. It flags reads taken while it is busy, wrong strobe widths, short spacings and byte-select changes during a strobe. It drives junk in the unused data bits so that a wrong capture cycle or a wrong nibble shows up in the sample.

// File: rtl/adc_byte_reader.sv
module adc_byte_reader #(
  parameter int PULSE_CYC    = 32,
  parameter int SPACE_CYC    = 50,
  parameter int SETTLE_CYC   = 23,
  parameter int CONV_GAP_CYC = 250,
  parameter int TIMEOUT_CYC  = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        conv_req,
  input  logic        conv_tick,
  output logic        sel_n,
  output logic        rd_n,
  output logic        hi_byte,
  input  logic        busy_n,
  input  logic [7:0]  bus_d,
  output logic [11:0] smp_data,
  output logic        smp_valid,
  input  logic        smp_ready,
  output logic        err_timeout
);

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int WAIT_CYC = mx(SETTLE_CYC, SPACE_CYC);
  localparam int MAXC     = mx(mx(mx(PULSE_CYC, WAIT_CYC), CONV_GAP_CYC), TIMEOUT_CYC);
  localparam int CW       = $clog2(MAXC + 1) + 1;

  localparam logic [CW-1:0] PULSE_END = CW'(PULSE_CYC - 1);
  localparam logic [CW-1:0] WAIT_END  = CW'(WAIT_CYC - 1);
  localparam logic [CW-1:0] SPACE_END = CW'(SPACE_CYC - 1);
  localparam logic [CW-1:0] TMO_END   = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] SPACE_MAX = CW'(SPACE_CYC);
  localparam logic [CW-1:0] GAP_MAX   = CW'(CONV_GAP_CYC);

  typedef enum logic [2:0] {
    S_IDLE, S_CONV, S_WAIT, S_SETTLE, S_RDLO, S_SPACE, S_RDHI, S_HOLD
  } st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [CW-1:0] gap_cnt;
  logic [1:0]    bsy_q;
  logic          seen_low;
  logic          pend;
  logic [7:0]    lo_q;
  logic          start;

  wire gap_ok  = gap_cnt >= GAP_MAX;
  wire idle_ok = (cnt >= SPACE_END) || (SPACE_CYC <= 1);
  wire busy_hi = bsy_q[1];

  assign start   = (state == S_IDLE) && pend && gap_ok && idle_ok;
  assign rd_n    = !((state == S_CONV) || (state == S_RDLO) || (state == S_RDHI));
  assign sel_n   = rd_n;
  assign hi_byte = (state == S_SPACE) || (state == S_RDHI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bsy_q <= 2'b11;
    else        bsy_q <= {bsy_q[0], busy_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= (pend && !start) || conv_req || conv_tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       gap_cnt <= GAP_MAX;
    else if (start)   gap_cnt <= CW'(1);
    else if (!gap_ok) gap_cnt <= gap_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      seen_low    <= 1'b0;
      lo_q        <= '0;
      smp_data    <= '0;
      smp_valid   <= 1'b0;
      err_timeout <= 1'b0;
    end else begin
      err_timeout <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state <= S_CONV;
            cnt   <= '0;
          end else if (cnt < SPACE_MAX) begin
            cnt <= cnt + CW'(1);
          end
        end
        S_CONV: begin
          if (cnt == PULSE_END) begin
            state    <= S_WAIT;
            cnt      <= '0;
            seen_low <= 1'b0;
          end else cnt <= cnt + CW'(1);
        end
        S_WAIT: begin
          if (!busy_hi) seen_low <= 1'b1;
          if (seen_low && busy_hi) begin
            state <= S_SETTLE;
            cnt   <= '0;
          end else if (cnt == TMO_END) begin
            state       <= S_IDLE;
            cnt         <= SPACE_MAX;
            err_timeout <= 1'b1;
          end else cnt <= cnt + CW'(1);
        end
        S_SETTLE: begin
          if (cnt == WAIT_END) begin
            state <= S_RDLO;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        S_RDLO: begin
          if (cnt == PULSE_END) begin
            lo_q  <= bus_d;
            state <= S_SPACE;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        S_SPACE: begin
          if (cnt == SPACE_END) begin
            state <= S_RDHI;
            cnt   <= '0;
          end else cnt <= cnt + CW'(1);
        end
        S_RDHI: begin
          if (cnt == PULSE_END) begin
            smp_data  <= {bus_d[3:0], lo_q};
            smp_valid <= 1'b1;
            state     <= S_HOLD;
            cnt       <= '0;
          end else cnt <= cnt + CW'(1);
        end
        S_HOLD: begin
          if (cnt < SPACE_MAX) cnt <= cnt + CW'(1);
          if (smp_ready) begin
            smp_valid <= 1'b0;
            state     <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // Checker counters observed by the assertions below
  logic [CW-1:0] chk_low, chk_high, chk_conv;
  wire conv_entry = (state == S_CONV) && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_low  <= '0;
      chk_high <= SPACE_MAX;
      chk_conv <= GAP_MAX;
    end else begin
      chk_low  <= rd_n ? '0 : chk_low + CW'(1);
      if (!rd_n)                chk_high <= '0;
      else if (chk_high < SPACE_MAX) chk_high <= chk_high + CW'(1);
      if (conv_entry)           chk_conv <= CW'(1);
      else if (chk_conv < GAP_MAX) chk_conv <= chk_conv + CW'(1);
    end
  end

  p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> chk_low == CW'(PULSE_CYC));

  p_read_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |-> chk_high >= SPACE_MAX);

  p_hisel_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && !$past(rd_n)) |-> $stable(hi_byte));

  p_conv_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    conv_entry |-> chk_conv >= GAP_MAX);

  p_hold_sample_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));

  p_quiet_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (rd_n && sel_n));

  p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> !err_timeout);

endmodule

// File: tb/adc_byte_reader_tb.sv
module adc_byte_reader_tb;
  localparam int PULSE  = 2;
  localparam int SPACE  = 3;
  localparam int SETTLE = 2;
  localparam int GAP    = 24;
  localparam int TMO    = 20;
  localparam int CONV_T = 6;

  logic clk = 0, rst_n = 0;
  logic conv_req = 0, conv_tick = 0, smp_ready = 0;
  logic busy_n = 1;
  logic [7:0] bus_d = 8'hA5;
  logic sel_n, rd_n, hi_byte, smp_valid, err_timeout;
  logic [11:0] smp_data;

  int tests = 0, fails = 0;
  int cyc = 0;

  // converter model state
  logic [11:0] next_val = 0, res = 0;
  logic armed = 1, dead = 0, in_conv = 0;
  int conv_left = 0;
  int low_run = 0, high_run = 1000, conv_count = 0, last_conv = -1000;
  logic prev_rd = 1, strobe_hi = 0, seen_strobe = 0;

  always #2 clk = ~clk;

  adc_byte_reader #(
    .PULSE_CYC(PULSE), .SPACE_CYC(SPACE), .SETTLE_CYC(SETTLE),
    .CONV_GAP_CYC(GAP), .TIMEOUT_CYC(TMO)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .conv_req(conv_req), .conv_tick(conv_tick),
    .sel_n(sel_n), .rd_n(rd_n), .hi_byte(hi_byte), .busy_n(busy_n),
    .bus_d(bus_d), .smp_data(smp_data), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .err_timeout(err_timeout)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // monitor and converter model, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (conv_left > 0) conv_left--;
      if (!rd_n && prev_rd) begin
        if (seen_strobe) check(high_run >= SPACE, "R5 read spacing", high_run, SPACE);
        check(sel_n == 0, "R2 select with read", sel_n, 0);
        seen_strobe = 1;
        strobe_hi = hi_byte;
        if (!hi_byte && armed) begin
          check(cyc - last_conv >= GAP, "R8 conversion spacing", cyc - last_conv, GAP);
          last_conv = cyc;
          conv_count++;
          if (!dead) begin
            armed = 0;
            in_conv = 1;
            res = next_val;
            conv_left = CONV_T;
          end
        end else begin
          check(conv_left == 0, "R3 read while busy", conv_left, 0);
          if (hi_byte) armed = 1;
        end
        low_run = 0;
      end
      if (!rd_n) begin
        low_run++;
        high_run = 0;
        if (!prev_rd) check(hi_byte == strobe_hi, "R5 byte select steady", hi_byte, strobe_hi);
        if (!in_conv) check(conv_left == 0, "R3 read while busy", conv_left, 0);
      end else begin
        if (!prev_rd) check(low_run == PULSE, "R6 strobe width", low_run, PULSE);
        high_run++;
        in_conv = 0;
      end
      if (smp_valid) check(rd_n == 1, "R7 no strobe while valid", rd_n, 1);
      prev_rd = rd_n;
    end
    busy_n = (conv_left == 0);
    if (!sel_n && !rd_n)
      bus_d = hi_byte ? {4'hC, res[11:8]} : res[7:0];
    else
      bus_d = 8'hA5;
  end

  task automatic tick_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(input bit use_tick);
    @(negedge clk);
    if (use_tick) conv_tick = 1; else conv_req = 1;
    @(negedge clk);
    conv_tick = 0;
    conv_req = 0;
  endtask

  task automatic wait_valid(output bit got);
    got = 0;
    for (int i = 0; i < 400; i++) begin
      if (smp_valid) begin got = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic accept(input logic [11:0] exp, input int delay);
    bit got;
    logic [11:0] held;
    wait_valid(got);
    check(got, "R7 sample presented", got, 1);
    if (!got) return;
    held = smp_data;
    for (int d = 0; d < delay; d++) begin
      @(negedge clk);
      check(smp_valid && smp_data == held, "R7 held until ready", smp_data, held);
    end
    check(smp_data[7:0] == exp[7:0], "R4 low byte", smp_data[7:0], exp[7:0]);
    check(smp_data[11:8] == exp[11:8], "R5 high nibble", smp_data[11:8], exp[11:8]);
    smp_ready = 1;
    @(negedge clk);
    smp_ready = 0;
    check(smp_valid == 0, "R7 valid falls after ready", smp_valid, 0);
  endtask

  initial begin : wdog
    tick_n(150000);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    int c0;
    int errs;
    bit got;
    tick_n(3);
    check(sel_n && rd_n && !hi_byte, "R1 strobes idle in reset", {sel_n, rd_n, hi_byte}, 3'b110);
    check(!smp_valid && !err_timeout, "R1 outputs low in reset", {smp_valid, err_timeout}, 0);
    rst_n = 1;
    tick_n(2);
    check(sel_n && rd_n && !hi_byte && !smp_valid, "R1 idle after reset", rd_n, 1);

    // sweep of codes, alternating request source (R10) and backpressure (R7)
    for (int v = 0; v < 4096; v += 13) begin
      next_val = 12'(v);
      pulse_req(v[0]);
      accept(12'(v), v % 5);
    end
    next_val = 12'hFFF;
    pulse_req(0);
    accept(12'hFFF, 0);
    next_val = 12'h800;
    pulse_req(1);
    accept(12'h800, 3);

    // queued request while a sample is held (R10, R7)
    next_val = 12'h3C5;
    pulse_req(0);
    wait_valid(got);
    c0 = conv_count;
    next_val = 12'h9A6;
    pulse_req(1);
    tick_n(GAP + 10);
    check(conv_count == c0, "R7 no start while sample held", conv_count, c0);
    accept(12'h3C5, 0);
    accept(12'h9A6, 0);
    check(conv_count == c0 + 1, "R10 queued request served", conv_count, c0 + 1);

    // converter never goes busy (R9)
    tick_n(GAP);
    dead = 1;
    errs = 0;
    c0 = conv_count;
    pulse_req(0);
    for (int i = 0; i < TMO + GAP + 20; i++) begin
      @(negedge clk);
      if (err_timeout) errs++;
      check(!smp_valid, "R9 no sample after timeout", smp_valid, 0);
    end
    check(errs == 1, "R9 single error pulse", errs, 1);
    check(conv_count == c0 + 1, "R9 only the start strobe", conv_count, c0 + 1);
    dead = 0;
    next_val = 12'h5A5;
    pulse_req(1);
    accept(12'h5A5, 1);
    check(err_timeout == 0, "R9 normal service after timeout", err_timeout, 0);

    tick_n(5);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule